// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the per-processor countdown timer of a local interrupt controller. Software programs it through a small write port that reaches three registers. The timer entry holds an interrupt vector, a mask bit and a mode bit that selects periodic or one-shot operation. The divide register selects a power-of-two prescale applied to the bus clock. Writing the start-count register loads the count. That write also restarts the timer's time reference and arms it.

From the load onward, the block counts prescaled ticks. Each time the tick count crosses an expiry point, it raises an interrupt request for one cycle and presents the vector from the timer entry. A one-shot timer expires once, when the tick count reaches start count plus one. A periodic timer expires at every multiple of (start count + 1) ticks. The current count is always readable on an output. The block does not prioritise interrupts, keep pending or in-service state, or send messages to other processors.

Top module: `lic_timer`

## Requirements
- R1: After reset, `irq_o` is 0 and `cur_count_o` is 0. The timer entry comes up masked, with vector 0 and one-shot mode. The start count is 0 and the timer is not armed, so no request is raised until software programs it.
- R2: The divide code is formed as {wr_data[3], wr_data[1], wr_data[0]} of a write to the divide register. Codes 0 to 6 give a shift of code+1, and code 7 gives a shift of 0. A prescaled tick falls on every 2^shift-th bus cycle after the start-count write.
- R3: In one-shot mode (timer entry bit 17 = 0), exactly one request is raised, in the cycle that follows the ((start+1) << shift)-th clock edge after the load edge. After that, no request is raised. `cur_count_o` reads start minus elapsed ticks while that value is positive, and 0 from then on.
- R4: In periodic mode (timer entry bit 17 = 1) with a non-zero start count, a request is raised after every edge k > 0 with k = n·((start+1) << shift). `cur_count_o` reads start − (elapsed ticks mod (start+1)).
- R5: In periodic mode with a start count of 0, the timer never raises a request, and `cur_count_o` reads 0.
- R6: While timer entry bit 16 (mask) is 1 at the expiry edge, no request is raised. The count keeps advancing, and `cur_count_o` follows R3/R4 as if unmasked.
- R7: A request is a single-cycle pulse on `irq_o`. During that cycle, `irq_vec_o` carries timer entry bits 7:0.
- R8: A write to the start-count register restarts the elapsed-tick reference at that edge and re-arms the timer, including after a one-shot timer has expired. The next cycle, `cur_count_o` reads the new start count.
- R9: Register select values: 0 is the timer entry, 1 is the start count, 2 is the divide register. A write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 timer entry, 1 start count, 2 divide) |
| wr_data | input | 32 | Write data |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | 8 | Vector presented with the request |
| cur_count_o | output | 32 | Current-count readback |

## Verification
The bench sweeps all eight divide codes against small start counts in both modes, and predicts every cycle's request and readback from the elapsed-tick arithmetic.

Several errors show up directly in this sweep:
- An off-by-one in the period (expiring at start instead of start+1) shifts every pulse one tick early.
- A wrong divide decode (for example, treating code 7 as divide by 256) moves the expiry by a whole power of two.
- A one-shot timer that fails to stop produces a second pulse.
- A periodic timer with a zero start count that is not disarmed fires on every tick.

Masked runs must stay silent while the readback still decrements. A select-3 write in mid-run must not disturb the count. A reload after expiry must restart from the new start count.

// File: rtl/lic_timer_pkg.sv
package lic_timer_pkg;
  localparam int MAX_SHIFT = 7;
  localparam int SH_W      = 3;
  localparam int LVT_MASK_BIT = 16;
  localparam int LVT_PER_BIT  = 17;

  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_START = 2'd1,
    SEL_DIV   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // Codes 0..6 map to shift code+1, code 7 wraps to shift 0.
  function automatic logic [SH_W-1:0] div_to_shift(input logic [3:0] cfg);
    logic [SH_W-1:0] code;
    code = {cfg[3], cfg[1], cfg[0]};
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/lic_timer_regs.sv
module lic_timer_regs
  import lic_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [VEC_W-1:0]  vec,
  output logic              masked,
  output logic              periodic,
  output logic [SH_W-1:0]   shift,
  output logic              load
);
  logic [3:0] div_q;
  logic       unused_hi;

  assign unused_hi = ^{wr_data[DATA_W-1:LVT_PER_BIT+1], wr_data[LVT_MASK_BIT-1:VEC_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      vec      <= '0;
      masked   <= 1'b1;
      periodic <= 1'b0;
      div_q    <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_ENTRY: begin
          vec      <= wr_data[VEC_W-1:0];
          masked   <= wr_data[LVT_MASK_BIT];
          periodic <= wr_data[LVT_PER_BIT];
        end
        SEL_DIV:   div_q <= wr_data[3:0];
        default:   ;
      endcase
    end
  end

  assign shift = div_to_shift(div_q);
  assign load  = wr_en && (reg_sel_e'(wr_sel) == SEL_START);
endmodule

// File: rtl/lic_timer_prescale.sv
module lic_timer_prescale
  import lic_timer_pkg::*;
#(
  parameter int PRE_W = MAX_SHIFT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [SH_W-1:0] shift,
  output logic            tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_inc;
  logic [PRE_W-1:0] msk;

  assign pre_inc = pre_q + 1'b1;
  assign msk     = PRE_W'((32'd1 << shift) - 32'd1);
  assign tick    = !load && ((pre_inc & msk) == '0);

  always_ff @(posedge clk) begin
    if (rst || load) pre_q <= '0;
    else             pre_q <= pre_inc;
  end
endmodule

// File: rtl/lic_timer_count.sv
module lic_timer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             periodic,
  input  logic             tick,
  output logic             fire,
  output logic [CNT_W-1:0] cur_count
);
  logic [CNT_W-1:0] ic_q, ph_q, ic_n, ph_n;
  logic             done_q, armed_q, dn_n, ar_n;

  always_comb begin
    ic_n = ic_q;
    ph_n = ph_q;
    dn_n = done_q;
    ar_n = armed_q;
    fire = 1'b0;
    if (load) begin
      ic_n = load_val;
      ph_n = '0;
      dn_n = 1'b0;
      ar_n = 1'b1;
    end else if (tick && armed_q && !done_q) begin
      if (ph_q == ic_q) begin
        if (!periodic) begin
          dn_n = 1'b1;
          fire = 1'b1;
        end else if (ic_q != '0) begin
          ph_n = '0;
          fire = 1'b1;
        end
      end else begin
        ph_n = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ic_q      <= '0;
      ph_q      <= '0;
      done_q    <= 1'b0;
      armed_q   <= 1'b0;
      cur_count <= '0;
    end else begin
      ic_q      <= ic_n;
      ph_q      <= ph_n;
      done_q    <= dn_n;
      armed_q   <= ar_n;
      cur_count <= (!ar_n || dn_n) ? '0 : ic_n - ph_n;
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> ph_q <= ic_q);  // R4
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    (fire && !periodic) |=> (cur_count == '0 && done_q));  // R3
  AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (fire && periodic) |=> cur_count == $past(ic_q));  // R4
  AST_ZERO_PERIOD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (periodic && ic_q == '0 && !load) |=> (ph_q == '0 && cur_count == '0));  // R5
endmodule

// File: rtl/lic_timer.sv
module lic_timer
  import lic_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic [CNT_W-1:0] cur_count_o
);
  logic [VEC_W-1:0] vec;
  logic             masked, periodic, load, tick, fire;
  logic [SH_W-1:0]  shift;

  lic_timer_regs #(.DATA_W(CNT_W), .VEC_W(VEC_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .vec(vec), .masked(masked), .periodic(periodic), .shift(shift), .load(load)
  );

  lic_timer_prescale #(.PRE_W(MAX_SHIFT)) i_pre (
    .clk(clk), .rst(rst), .load(load), .shift(shift), .tick(tick)
  );

  lic_timer_count #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(wr_data), .periodic(periodic),
    .tick(tick), .fire(fire), .cur_count(cur_count_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      irq_vec_o <= '0;
    end else begin
      irq_o <= fire && !masked;
      if (fire && !masked) irq_vec_o <= vec;
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);  // R7
  AST_IRQ_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(tick));  // R2
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> !$past(masked));  // R6
endmodule

// File: tb/test_lic_timer.sv
module test_lic_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        irq_o;
  logic [7:0]  irq_vec_o;
  logic [31:0] cur_count_o;
  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lic_timer i_lic_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_o(irq_o), .irq_vec_o(irq_vec_o), .cur_count_o(cur_count_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // Program, load, then compare every cycle against the elapsed-tick model.
  task automatic run(input int ic, input int code, input bit per, input bit msk,
                     input logic [7:0] vec, input bit poke, input string tag);
    int sh, period_c, ncyc, d, ecur, pulses;
    bit eirq;
    sh = (code + 1) % 8;
    period_c = (ic + 1) << sh;
    ncyc = per ? 3 * period_c + 4 : period_c + (2 << sh) + 4;
    wr(2'd0, {14'd0, per, msk, 8'd0, vec});
    wr(2'd2, {28'd0, code[2], 1'b0, code[1], code[0]});
    wr(2'd1, ic);
    chk(cur_count_o == ic, "R8 reload", cur_count_o, ic);
    pulses = 0;
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      if (poke && k == 3) begin wr_en = 1'b1; wr_sel = 2'd3; wr_data = '1; end
      if (poke && k == 4) begin wr_en = 1'b0; wr_data = '0; end
      d = k >> sh;
      if (per) begin
        eirq = (ic != 0) && (k % period_c == 0);
        ecur = ic - (d % (ic + 1));
      end else begin
        eirq = (k == period_c);
        ecur = (d >= ic) ? 0 : ic - d;
      end
      eirq = eirq && !msk;
      if (irq_o) pulses++;
      chk(irq_o == eirq, tag, irq_o, eirq);
      chk(cur_count_o == ecur, tag, cur_count_o, ecur);
      if (eirq) chk(irq_vec_o == vec, "R7 vector", irq_vec_o, vec);
    end
    if (!per && !msk) chk(pulses == 1, "R3 single pulse", pulses, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
      chk(cur_count_o == 0, "R1 count", cur_count_o, 0);
    end
    // R1: entry masked after reset; loading a count alone must stay silent.
    wr(2'd1, 32'd2);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(irq_o == 1'b0, "R1 masked after reset", irq_o, 0);
    end
    for (int code = 0; code < 8; code++) begin
      for (int ic = 0; ic < 4; ic++) begin
        run(ic, code, 1'b0, 1'b0, 8'(8'h20 + ic), 1'b0, "R2 R3 one-shot");
        run(ic, code, 1'b1, 1'b0, 8'(8'hC0 + code), 1'b0, (ic == 0) ? "R5 zero period" : "R4 periodic");
      end
    end
    run(2, 7, 1'b0, 1'b1, 8'h55, 1'b0, "R6 masked one-shot");
    run(1, 0, 1'b1, 1'b1, 8'h66, 1'b0, "R6 masked periodic");
    run(3, 7, 1'b1, 1'b0, 8'h77, 1'b1, "R9 ignored select");
    run(5, 1, 1'b0, 1'b0, 8'hFE, 1'b1, "R9 ignored select");
    run(2, 7, 1'b0, 1'b0, 8'h11, 1'b0, "R8 re-arm");
    run(2, 7, 1'b0, 1'b0, 8'h12, 1'b0, "R8 re-arm");
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule